// File: doc/BRIEF.md
# Synchronous Serial Shift Interface Controller

This block moves one byte at a time over a three-wire synchronous serial link for a small microcontroller. A state machine and a 3-bit bit counter control the transfer. The serial clock comes either from an external master or from an internal divider of the system clock. The CPU loads the shift register and selects the clock source with a mode-register write. It arms a transfer with a start command and learns of completion through an interrupt request flag.

The external clock is brought into the system clock domain by a synchronizer with an edge detector. Each falling edge drives the next bit out on `sdOut`, least significant bit first. Each rising edge samples `sdIn` into the shift register. If the CPU restarts or reconfigures the interface in the middle of a byte, the transfer is aborted and the interrupt flag is raised, so that software sees an overrun or a burst of clock noise. An abort inside the first low clock phase does not raise the flag. In internal clock mode, with the port-mode bits at 00, the block can also drive a free-running clock.

Top module: `ser_shift_top`

## Requirements
- R1: After reset `stateOut` is 0 (start-wait), `irqFlag` is 0, `sckOe` is 0, and both `sdOut` and `sckOut` are 1.
- R2: A start command in start-wait moves `stateOut` to 1 (clock-wait), unless internal mode with port-mode bits 00 is selected. A mode write in clock-wait returns `stateOut` to 0.
- R3: In start-wait, edges on the serial clock are ignored and `stateOut` stays 0.
- R4: In clock-wait a serial clock falling edge enters transfer (`stateOut` 2). The eighth rising edge sets `irqFlag` and returns `stateOut` to 1. A further falling edge starts a new transfer.
- R5: Data is sent least significant bit first. After the (i+1)-th falling edge, `sdOut` shows bit i of the loaded byte. Each rising edge samples `sdIn`. After eight bits `dataOut` holds the received byte, with the first bit received in bit 0.
- R6: `irqFlag` stays set until an `irqClr` pulse. When a set event and `irqClr` fall in the same cycle, the flag ends up set.
- R7: In transfer, once the first rising edge has passed, a start command moves `stateOut` to 1 and a mode write moves it to 0. Both set `irqFlag`.
- R8: An abort of the kind in R7, made before the first rising edge of a transfer, changes state but leaves `irqFlag` clear.
- R9: A `dataWr` outside transfer loads `dataIn` into the shift register. A `dataWr` during transfer is ignored.
- R10: A mode write with `modeIntClk`=1 selects internal mode. `sckOe` becomes 1, a start yields exactly eight clock pulses on `sckOut` with a half period of DIV_HALF system clocks, and `sckOut` idles high afterwards.
- R11: In internal mode with port-mode bits 00, a start enters the continuous clock state (`stateOut` 3). `sckOut` toggles until a mode write returns `stateOut` to 0.
- R12: A port-mode write in clock-wait or transfer moves `stateOut` to 4. Start commands and clock edges are then ignored until a mode write returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| modeWr | input | 1 | Mode-register write strobe |
| modeIntClk | input | 1 | Clock source written with `modeWr`: 1 internal, 0 external |
| startCmd | input | 1 | Start command strobe |
| portModeWr | input | 1 | Port-mode register write strobe |
| portModeBits | input | 2 | Low port-mode bits written with `portModeWr` |
| irqClr | input | 1 | Interrupt flag clear strobe |
| dataWr | input | 1 | Shift register write strobe |
| dataIn | input | 8 | Byte written to the shift register |
| dataOut | output | 8 | Shift register contents |
| sckIn | input | 1 | Serial clock from the pin (external mode) |
| sckOut | output | 1 | Serial clock driven in internal mode |
| sckOe | output | 1 | Serial clock output enable |
| sdIn | input | 1 | Serial data input |
| sdOut | output | 1 | Serial data output |
| irqFlag | output | 1 | Interrupt request flag |
| stateOut | output | 3 | State: 0 start-wait, 1 clock-wait, 2 transfer, 3 continuous clock, 4 stalled |

## Verification
An external clock edge reaches the state, the counter and `sdOut` three system clock edges after `sckIn` changes: two synchronizer stages plus the edge register. The bench therefore holds each `sckIn` level for four cycles and samples on the falling edge of `clk` at the end of that hold. Strobes such as `startCmd`, `modeWr` and `irqClr` take effect at the next rising edge, and the bench checks them one cycle later. For the set-versus-clear case, `irqClr` is placed in the exact cycle in which the eighth rising edge is detected. In internal mode, state and data update on the same edge that toggles `sckOut`, so the bench times its samples from the edges of `sckOut` itself.

// File: rtl/ser_shift_pkg.sv
package ser_shift_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CKWAIT = 3'd1,
    ST_XFER   = 3'd2,
    ST_CONT   = 3'd3,
    ST_STALL  = 3'd4
  } serState_e;

  typedef struct packed {
    logic loadData;
    logic shiftOut;
    logic shiftIn;
    logic genEn;
  } serStb_t;

endpackage

// File: rtl/ser_shift_ctrl.sv
module ser_shift_ctrl
  import ser_shift_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       modeWr,
  input  logic       modeIntClk,
  input  logic       startCmd,
  input  logic       portModeWr,
  input  logic [1:0] portModeBits,
  input  logic       irqClr,
  input  logic       dataWr,
  input  logic       fallEv,
  input  logic       riseEv,
  output serStb_t    stb,
  output serState_e  state,
  output logic       intMode,
  output logic       irqFlag
);

  localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  serState_e     st, nxt;
  logic [CW-1:0] cnt, cntNxt;
  logic          armed, armNxt;
  logic          firstLow, firstNxt;
  logic          setIrq;
  logic [1:0]    pmQ;

  always_comb begin
    nxt          = st;
    cntNxt       = cnt;
    armNxt       = armed;
    firstNxt     = firstLow;
    setIrq       = 1'b0;
    stb          = '0;
    stb.loadData = dataWr && (st != ST_XFER);
    stb.genEn    = intMode && ((st == ST_CONT) || (st == ST_XFER) ||
                               ((st == ST_CKWAIT) && armed));
    case (st)
      ST_IDLE: begin
        if (!modeWr && startCmd) begin
          armNxt = 1'b1;
          nxt    = (intMode && pmQ == 2'b00) ? ST_CONT : ST_CKWAIT;
        end
      end
      ST_CKWAIT: begin
        if (modeWr) begin
          nxt    = ST_IDLE;
          armNxt = 1'b0;
        end else if (startCmd) begin
          armNxt = 1'b1;
        end else if (portModeWr) begin
          nxt    = ST_STALL;
          armNxt = 1'b0;
        end else if (fallEv) begin
          nxt          = ST_XFER;
          cntNxt       = '0;
          firstNxt     = 1'b1;
          armNxt       = 1'b0;
          stb.shiftOut = 1'b1;
        end
      end
      ST_XFER: begin
        if (modeWr) begin
          nxt    = ST_IDLE;
          setIrq = !firstLow;
        end else if (startCmd) begin
          nxt    = ST_CKWAIT;
          setIrq = !firstLow;
          armNxt = 1'b1;
        end else if (portModeWr) begin
          nxt = ST_STALL;
        end else if (riseEv) begin
          stb.shiftIn = 1'b1;
          firstNxt    = 1'b0;
          cntNxt      = cnt + 1'b1;
          if (cnt == LAST) begin
            nxt    = ST_CKWAIT;
            setIrq = 1'b1;
          end
        end else if (fallEv) begin
          stb.shiftOut = 1'b1;
        end
      end
      ST_CONT, ST_STALL: begin
        if (modeWr) begin
          nxt    = ST_IDLE;
          armNxt = 1'b0;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      armed    <= 1'b0;
      firstLow <= 1'b0;
      intMode  <= 1'b0;
      pmQ      <= 2'b01;
      irqFlag  <= 1'b0;
    end else begin
      st       <= nxt;
      cnt      <= cntNxt;
      armed    <= armNxt;
      firstLow <= firstNxt;
      if (modeWr)     intMode <= modeIntClk;
      if (portModeWr) pmQ     <= portModeBits;
      if (setIrq)      irqFlag <= 1'b1;
      else if (irqClr) irqFlag <= 1'b0;
    end
  end

  assign state = st;

endmodule

// File: rtl/ser_shift_dp.sv
module ser_shift_dp
  import ser_shift_pkg::*;
#(
  parameter int BITS        = 8,
  parameter int DIV_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  serStb_t         stb,
  input  logic            intMode,
  input  logic [BITS-1:0] dataIn,
  input  logic            sckIn,
  input  logic            sdIn,
  output logic            fallEv,
  output logic            riseEv,
  output logic [BITS-1:0] dataOut,
  output logic            sdOut,
  output logic            sckOut
);

  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [DW-1:0] DLAST = DW'(DIV_HALF - 1);

  logic [SYNC_STAGES:0]   sckPipe;
  logic [SYNC_STAGES-1:0] sdPipe;
  logic                   sdBit, extFall, extRise, intFall, intRise, tick;
  logic [DW-1:0]          divCnt;
  logic                   clkLvl;
  logic [BITS-1:0]        sr;
  logic                   sdOutQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckPipe <= '1;
      sdPipe  <= '0;
    end else begin
      sckPipe <= {sckPipe[SYNC_STAGES-1:0], sckIn};
      sdPipe  <= {sdPipe[SYNC_STAGES-2:0], sdIn};
    end
  end

  assign sdBit   = sdPipe[SYNC_STAGES-1];
  assign extFall = sckPipe[SYNC_STAGES] & ~sckPipe[SYNC_STAGES-1];
  assign extRise = ~sckPipe[SYNC_STAGES] & sckPipe[SYNC_STAGES-1];

  assign tick    = (divCnt == DLAST);
  assign intFall = stb.genEn && tick && clkLvl;
  assign intRise = stb.genEn && tick && !clkLvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
      clkLvl <= 1'b1;
    end else if (!stb.genEn) begin
      divCnt <= '0;
      clkLvl <= 1'b1;
    end else if (tick) begin
      divCnt <= '0;
      clkLvl <= ~clkLvl;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign fallEv = intMode ? intFall : extFall;
  assign riseEv = intMode ? intRise : extRise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      sdOutQ <= 1'b1;
    end else begin
      if (stb.loadData)     sr <= dataIn;
      else if (stb.shiftIn) sr <= {sdBit, sr[BITS-1:1]};
      if (stb.shiftOut) sdOutQ <= sr[0];
    end
  end

  assign dataOut = sr;
  assign sdOut   = sdOutQ;
  assign sckOut  = clkLvl;

endmodule

// File: rtl/ser_shift_top.sv
module ser_shift_top
  import ser_shift_pkg::*;
#(
  parameter int BITS        = 8,
  parameter int DIV_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            modeWr,
  input  logic            modeIntClk,
  input  logic            startCmd,
  input  logic            portModeWr,
  input  logic [1:0]      portModeBits,
  input  logic            irqClr,
  input  logic            dataWr,
  input  logic [BITS-1:0] dataIn,
  output logic [BITS-1:0] dataOut,
  input  logic            sckIn,
  output logic            sckOut,
  output logic            sckOe,
  input  logic            sdIn,
  output logic            sdOut,
  output logic            irqFlag,
  output logic [2:0]      stateOut
);

  serStb_t   stb;
  serState_e state;
  logic      intMode, fallEv, riseEv;

  ser_shift_ctrl #(.BITS(BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .modeWr(modeWr), .modeIntClk(modeIntClk),
    .startCmd(startCmd), .portModeWr(portModeWr), .portModeBits(portModeBits),
    .irqClr(irqClr), .dataWr(dataWr), .fallEv(fallEv), .riseEv(riseEv),
    .stb(stb), .state(state), .intMode(intMode), .irqFlag(irqFlag)
  );

  ser_shift_dp #(.BITS(BITS), .DIV_HALF(DIV_HALF), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .intMode(intMode), .dataIn(dataIn),
    .sckIn(sckIn), .sdIn(sdIn), .fallEv(fallEv), .riseEv(riseEv),
    .dataOut(dataOut), .sdOut(sdOut), .sckOut(sckOut)
  );

  assign sckOe    = intMode;
  assign stateOut = state;

endmodule

// File: rtl/ser_shift_chk.sv
module ser_shift_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       modeWr,
  input logic       startCmd,
  input logic       irqClr,
  input logic       irqFlag,
  input logic [2:0] stateOut
);

  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irqFlag && !irqClr) |=> irqFlag);

  a_r7_mode_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (stateOut == 3'd2 && modeWr) |=> (stateOut == 3'd0));

  a_r2_start_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stateOut == 3'd0 && startCmd && !modeWr) |=> (stateOut == 3'd1 || stateOut == 3'd3));

  a_r3_idle_no_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (stateOut == 3'd0) |=> (stateOut != 3'd2));

  a_r12_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stateOut == 3'd4 && !modeWr) |=> (stateOut == 3'd4));

  a_r11_cont_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stateOut == 3'd3 && !modeWr) |=> (stateOut == 3'd3));

endmodule

bind ser_shift_top ser_shift_chk i_chk (
  .clk(clk), .rst_n(rst_n), .modeWr(modeWr), .startCmd(startCmd),
  .irqClr(irqClr), .irqFlag(irqFlag), .stateOut(stateOut)
);

// File: tb/test_ser_shift_top.sv
module test_ser_shift_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       modeWr = 1'b0, modeIntClk = 1'b0, startCmd = 1'b0;
  logic       portModeWr = 1'b0;
  logic [1:0] portModeBits = 2'b01;
  logic       irqClr = 1'b0, dataWr = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dataOut;
  logic       sckIn = 1'b1, sckOut, sckOe, sdIn = 1'b0, sdOut, irqFlag;
  logic [2:0] stateOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ser_shift_top i_ser_shift_top (
    .clk(clk), .rst_n(rst_n), .modeWr(modeWr), .modeIntClk(modeIntClk),
    .startCmd(startCmd), .portModeWr(portModeWr), .portModeBits(portModeBits),
    .irqClr(irqClr), .dataWr(dataWr), .dataIn(dataIn), .dataOut(dataOut),
    .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe), .sdIn(sdIn), .sdOut(sdOut),
    .irqFlag(irqFlag), .stateOut(stateOut)
  );

  // tx byte in the upper half, byte driven on sdIn in the lower half
  localparam logic [15:0] VEC [0:3] = '{16'hA53C, 16'h0FF0, 16'h8001, 16'h00FF};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseMode(input logic intClk);
    modeWr = 1'b1; modeIntClk = intClk; tick(1); modeWr = 1'b0; tick(1);
  endtask
  task automatic pulseStart();
    startCmd = 1'b1; tick(1); startCmd = 1'b0; tick(1);
  endtask
  task automatic pulseClr();
    irqClr = 1'b1; tick(1); irqClr = 1'b0; tick(1);
  endtask
  task automatic writeData(input logic [7:0] d);
    dataWr = 1'b1; dataIn = d; tick(1); dataWr = 1'b0; tick(1);
  endtask
  task automatic writePort(input logic [1:0] b);
    portModeWr = 1'b1; portModeBits = b; tick(1); portModeWr = 1'b0; tick(1);
  endtask

  // eight external clock periods; checks every sent bit (R5)
  task automatic extByte(input logic [7:0] tx, input logic [7:0] rx, input logic midWr);
    for (int i = 0; i < 8; i++) begin
      sckIn = 1'b0; sdIn = rx[i]; tick(4);
      chk("R5 sdOut bit", {31'd0, sdOut}, {31'd0, tx[i]});
      if (i == 0) chk("R4 enter transfer", {29'd0, stateOut}, 32'd2);
      if (midWr && i == 4) begin
        dataWr = 1'b1; dataIn = 8'h11; tick(1); dataWr = 1'b0;
      end
      sckIn = 1'b1; tick(4);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int toggles;
    logic last;
    tick(3); rst_n = 1'b1; tick(1);

    // R1 reset values
    chk("R1 state", {29'd0, stateOut}, 32'd0);
    chk("R1 irq", {31'd0, irqFlag}, 32'd0);
    chk("R1 sckOe", {31'd0, sckOe}, 32'd0);
    chk("R1 sdOut", {31'd0, sdOut}, 32'd1);
    chk("R1 sckOut", {31'd0, sckOut}, 32'd1);

    // R3 clock ignored in start-wait
    sckIn = 1'b0; tick(4);
    chk("R3 fall ignored", {29'd0, stateOut}, 32'd0);
    sckIn = 1'b1; tick(4);

    // R2 start and mode write
    pulseStart();
    chk("R2 start to clock-wait", {29'd0, stateOut}, 32'd1);
    pulseMode(1'b0);
    chk("R2 mode write to start-wait", {29'd0, stateOut}, 32'd0);

    // table walk: R4, R5, R9 (load outside transfer)
    foreach (VEC[k]) begin
      pulseClr();
      writeData(VEC[k][15:8]);
      chk("R9 load", {24'd0, dataOut}, {24'd0, VEC[k][15:8]});
      pulseStart();
      chk("R2 armed", {29'd0, stateOut}, 32'd1);
      extByte(VEC[k][15:8], VEC[k][7:0], 1'b0);
      chk("R4 flag after eight", {31'd0, irqFlag}, 32'd1);
      chk("R4 back to clock-wait", {29'd0, stateOut}, 32'd1);
      chk("R5 received byte", {24'd0, dataOut}, {24'd0, VEC[k][7:0]});
    end

    // R4 spurious extra edge, R8 abort in first low pulse
    pulseClr();
    sckIn = 1'b0; tick(4);
    chk("R4 extra edge starts transfer", {29'd0, stateOut}, 32'd2);
    pulseMode(1'b0);
    chk("R8 abort state", {29'd0, stateOut}, 32'd0);
    chk("R8 no flag", {31'd0, irqFlag}, 32'd0);
    sckIn = 1'b1; tick(4);
    chk("R3 rise ignored", {29'd0, stateOut}, 32'd0);

    // R7 start abort after first rise
    pulseStart();
    sckIn = 1'b0; tick(4); sckIn = 1'b1; tick(4);
    pulseStart();
    chk("R7 start abort state", {29'd0, stateOut}, 32'd1);
    chk("R7 start abort flag", {31'd0, irqFlag}, 32'd1);
    pulseClr();
    sckIn = 1'b0; tick(4);
    chk("R4 restart", {29'd0, stateOut}, 32'd2);
    sckIn = 1'b1; tick(4);
    pulseMode(1'b0);
    chk("R7 mode abort state", {29'd0, stateOut}, 32'd0);
    chk("R7 mode abort flag", {31'd0, irqFlag}, 32'd1);

    // R6 hold then clear
    tick(10);
    chk("R6 flag held", {31'd0, irqFlag}, 32'd1);
    pulseClr();
    chk("R6 flag cleared", {31'd0, irqFlag}, 32'd0);

    // R6 set and clear in the same cycle
    writeData(8'h00);
    pulseStart();
    for (int i = 0; i < 7; i++) begin
      sckIn = 1'b0; tick(4); sckIn = 1'b1; tick(4);
    end
    sckIn = 1'b0; tick(4);
    sckIn = 1'b1; tick(2);
    irqClr = 1'b1; tick(1); irqClr = 1'b0;
    chk("R6 set wins", {31'd0, irqFlag}, 32'd1);
    tick(3);
    pulseClr();
    chk("R6 cleared after collision", {31'd0, irqFlag}, 32'd0);

    // R9 write during transfer ignored
    writeData(8'hC3);
    pulseStart();
    extByte(8'hC3, 8'h96, 1'b1);
    chk("R9 write in transfer ignored", {24'd0, dataOut}, 32'h96);

    // R12 port-mode write in clock-wait
    writePort(2'b10);
    chk("R12 stalled", {29'd0, stateOut}, 32'd4);
    pulseStart();
    sckIn = 1'b0; tick(4); sckIn = 1'b1; tick(4);
    chk("R12 start and edges ignored", {29'd0, stateOut}, 32'd4);
    pulseMode(1'b0);
    chk("R12 mode write exits", {29'd0, stateOut}, 32'd0);

    // R10 internal clock transfer
    pulseMode(1'b1);
    chk("R10 sckOe", {31'd0, sckOe}, 32'd1);
    sdIn = 1'b1;
    pulseClr();
    writeData(8'h5A);
    startCmd = 1'b1; tick(1); startCmd = 1'b0;
    got = 8'h00;
    for (int i = 0; i < 8; i++) begin
      @(posedge sckOut);
      got[i] = sdOut;
    end
    tick(2);
    chk("R5 internal sent bits", {24'd0, got}, 32'h5A);
    chk("R5 internal received", {24'd0, dataOut}, 32'hFF);
    chk("R10 flag", {31'd0, irqFlag}, 32'd1);
    chk("R10 clock-wait", {29'd0, stateOut}, 32'd1);
    toggles = 0; last = sckOut;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (sckOut !== last) toggles++;
      last = sckOut;
    end
    chk("R10 clock idles high", {31'd0, sckOut}, 32'd1);
    chk("R10 no extra pulses", toggles, 32'd0);

    // R11 continuous clock
    pulseMode(1'b1);
    writePort(2'b00);
    pulseStart();
    chk("R11 continuous state", {29'd0, stateOut}, 32'd3);
    toggles = 0; last = sckOut;
    for (int i = 0; i < 64; i++) begin
      tick(1);
      if (sckOut !== last) toggles++;
      last = sckOut;
    end
    chk("R11 clock toggles", {31'd0, toggles >= 12}, 32'd1);
    pulseMode(1'b1);
    chk("R11 mode write exits", {29'd0, stateOut}, 32'd0);
    tick(2);
    chk("R11 clock back high", {31'd0, sckOut}, 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule